// File: doc/BRIEF.md
# Filter VM Integer Execution Unit

This block is the integer datapath of a small packet-filter virtual machine. Each cycle it can accept one decoded arithmetic, logic, move or byte-order instruction, together with the current destination register value, the source register value and the sign-extended immediate. One clock later it returns the value to write into the destination register, a write strobe and an error strobe. The register file, memory and branches sit around it and are not part of it.

The instruction class picks the operating width. The wide class works on all 64 bits. The narrow class works on the low 32 bits as unsigned values, and its result is zero-extended into the 64-bit register.

The byte-order instruction gives two of its fields a different meaning. Its source selector picks the target byte order. Its immediate picks the conversion width.

Top module: `fvm_alu`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and stays low one clock after a cycle with `in_valid` low. `wr_en` and `err` are only ever high together with `out_valid`.
- R2: The second operand is `imm_val` when `src_sel` is 0 and `src_val` when `src_sel` is 1.
- R3: For wide class `op_class`=3'b111, `op_code` gives the operation on 64-bit values, and every result overwrites the destination:
  - 0 = add, 1 = subtract, 2 = multiply (low half), 4 = OR, 5 = AND.
  - 10 = XOR, 11 = move the second operand, 8 = negate the destination (a unary operation).
- R4: Narrow class `op_class`=3'b100 uses only bits 31:0 of both operands and produces a 32-bit result, zero-extended to 64 bits. Modulo by zero and byte-order conversion are the only exceptions.
- R5: Shifts are as follows. Code 6 is a logical left shift, 7 a logical right shift and 12 an arithmetic right shift. The shift count is the second operand masked to 6 bits in wide class and to 5 bits in narrow class.
- R6: Code 3 (unsigned divide) by zero yields 0. Code 9 (unsigned modulo) by zero writes back the full 64-bit destination value unchanged.
- R7: Code 13 converts byte order within the width `imm_val` (16, 32 or 64), in either class. With the default little-endian host, `src_sel`=0 (target little-endian) only truncates to that width. With `src_sel`=1 (target big-endian) it reverses the byte order within that width. Bits above the width are zero. A big-endian host (`HOST_BE`=1) swaps these two roles.
- R8: Code 13 with any other `imm_val` raises `err`, keeps `wr_en` low and drives `wr_data` to zero.
- R9: Codes 14 and 15, and any class other than 3'b100 or 3'b111, raise `err` with `wr_en` low and `wr_data` zero.
- R10: While `rst_n` is low, `out_valid`, `wr_en`, `err` and `wr_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_code | input | 4 | Operation code |
| src_sel | input | 1 | Operand select / byte-order target |
| op_class | input | 3 | Instruction class (3'b100 narrow, 3'b111 wide) |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 64 | Sign-extended immediate |
| out_valid | output | 1 | Result present |
| wr_en | output | 1 | Write the result to the destination |
| err | output | 1 | Instruction rejected |
| wr_data | output | 64 | Result value |

## Verification
The assertions assume that the decode fields are valid in the same cycle as `in_valid`. Their `$past` lookbacks rely on this, because they read the class, code and immediate from the cycle before. The stimulus drives all fields together on the falling edge and holds them for a full clock, so each field is stable at the capturing edge. The sweep covers every code (including the illegal ones) and a non-ALU class. The operand patterns include zero, sign-bit values, shift counts at and above the mask, and the three legal byte-order widths next to illegal ones.

// File: rtl/fvm_alu.sv
module fvm_alu #(
  parameter int DATA_W  = 64,
  parameter bit HOST_BE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic              src_sel,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] imm_val,
  output logic              out_valid,
  output logic              wr_en,
  output logic              err,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HW = DATA_W / 2;
  localparam int SW = $clog2(DATA_W);
  localparam int NB = DATA_W / 8;

  logic is_wide, is_narrow, is_end, width_ok, bad, do_swap;
  logic [DATA_W-1:0] opb, res_w, res_e, rev, picked, res;
  logic [HW-1:0] a_n, b_n, res_n;

  assign is_wide   = (op_class == 3'b111);
  assign is_narrow = (op_class == 3'b100);
  assign is_end    = (op_code == 4'hD);
  assign opb       = src_sel ? src_val : imm_val;
  assign a_n       = dst_val[HW-1:0];
  assign b_n       = opb[HW-1:0];

  always_comb begin
    case (op_code)
      4'h0: res_w = dst_val + opb;
      4'h1: res_w = dst_val - opb;
      4'h2: res_w = dst_val * opb;
      4'h3: res_w = (opb == '0) ? '0 : dst_val / opb;
      4'h4: res_w = dst_val | opb;
      4'h5: res_w = dst_val & opb;
      4'h6: res_w = dst_val << opb[SW-1:0];
      4'h7: res_w = dst_val >> opb[SW-1:0];
      4'h8: res_w = '0 - dst_val;
      4'h9: res_w = (opb == '0) ? dst_val : dst_val % opb;
      4'hA: res_w = dst_val ^ opb;
      4'hB: res_w = opb;
      4'hC: res_w = $unsigned($signed(dst_val) >>> opb[SW-1:0]);
      default: res_w = '0;
    endcase
  end

  always_comb begin
    case (op_code)
      4'h0: res_n = a_n + b_n;
      4'h1: res_n = a_n - b_n;
      4'h2: res_n = a_n * b_n;
      4'h3: res_n = (b_n == '0) ? '0 : a_n / b_n;
      4'h4: res_n = a_n | b_n;
      4'h5: res_n = a_n & b_n;
      4'h6: res_n = a_n << b_n[SW-2:0];
      4'h7: res_n = a_n >> b_n[SW-2:0];
      4'h8: res_n = '0 - a_n;
      4'h9: res_n = (b_n == '0) ? '0 : a_n % b_n;
      4'hA: res_n = a_n ^ b_n;
      4'hB: res_n = b_n;
      4'hC: res_n = $unsigned($signed(a_n) >>> b_n[SW-2:0]);
      default: res_n = '0;
    endcase
  end

  for (genvar k = 0; k < NB; k++) begin : g_rev
    assign rev[8*k +: 8] = dst_val[8*(NB-1-k) +: 8];
  end

  assign do_swap  = src_sel ^ HOST_BE;
  assign width_ok = (imm_val == 64'd16) || (imm_val == 64'd32) || (imm_val == DATA_W);
  assign picked   = do_swap ? rev : dst_val;

  always_comb begin
    res_e = '0;
    if (imm_val == 64'd16)
      res_e[15:0] = do_swap ? rev[DATA_W-1 -: 16] : picked[15:0];
    else if (imm_val == 64'd32)
      res_e[31:0] = do_swap ? rev[DATA_W-1 -: 32] : picked[31:0];
    else
      res_e = picked;
  end

  assign bad = !(is_wide || is_narrow) || (op_code > 4'hD) || (is_end && !width_ok);

  always_comb begin
    if (is_end)                                       res = res_e;
    else if (is_narrow && op_code == 4'h9 && b_n == '0) res = dst_val;
    else if (is_narrow)                               res = {{(DATA_W-HW){1'b0}}, res_n};
    else                                              res = res_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      err       <= 1'b0;
      wr_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && !bad;
      err       <= in_valid && bad;
      wr_data   <= (in_valid && !bad) ? res : '0;
    end
  end
endmodule

// File: rtl/fvm_alu_chk.sv
module fvm_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op_code,
  input logic [2:0]        op_class,
  input logic [DATA_W-1:0] imm_val,
  input logic              out_valid,
  input logic              wr_en,
  input logic              err,
  input logic [DATA_W-1:0] wr_data
);
  AST_LATENCY_HI: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_LATENCY_LO: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_n) (wr_en || err) |-> out_valid); // R1
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!wr_en && wr_data == '0)); // R8
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(op_class) == 3'b100 && $past(op_code) != 4'h9 && $past(op_code) != 4'hD)
      |-> wr_data[DATA_W-1:DATA_W/2] == '0); // R4
  AST_BAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) == 4'hD && $past(imm_val) != 64'd16 && $past(imm_val) != 64'd32
      && $past(imm_val) != 64'd64) |-> err); // R8
  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_class) != 3'b100 && $past(op_class) != 3'b111) |-> err); // R9
endmodule

bind fvm_alu fvm_alu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/fvm_alu_tb_top.sv
module fvm_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic src_sel = 1'b0;
  logic [2:0] op_class = '0;
  logic [63:0] dst_val = '0, src_val = '0, imm_val = '0;
  logic out_valid, wr_en, err;
  logic [63:0] wr_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fvm_alu dut_i (.*);

  function automatic logic [63:0] pat(int n);
    case (n)
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h1234_5678_9ABC_DEF0;
      5: return 64'h0000_0000_FFFF_FFFF;
      6: return 64'd16;
      7: return 64'd32;
      8: return 64'd64;
      9: return 64'h0000_0000_8000_0000;
      default: return 64'd33;
    endcase
  endfunction

  // returns {err, data}
  function automatic logic [64:0] model(int op, int cls, bit sel, logic [63:0] d, s, i);
    logic [63:0] b, x, y, r, m;
    int nb;
    b = sel ? s : i;
    m = 64'hFFFF_FFFF;
    if (!(cls == 7 || cls == 4) || op > 13) return {1'b1, 64'd0};
    if (op == 13) begin
      if (i != 16 && i != 32 && i != 64) return {1'b1, 64'd0};
      nb = int'(i) / 8;
      r = '0;
      for (int k = 0; k < nb; k++)
        r[8*k +: 8] = sel ? d[8*(nb-1-k) +: 8] : d[8*k +: 8];
      return {1'b0, r};
    end
    x = (cls == 4) ? (d & m) : d;
    y = (cls == 4) ? (b & m) : b;
    case (op)
      0: r = x + y;
      1: r = x - y;
      2: r = x * y;
      3: r = (y == 0) ? 64'd0 : x / y;
      4: r = x | y;
      5: r = x & y;
      6: r = (cls == 4) ? x << y[4:0] : x << y[5:0];
      7: r = (cls == 4) ? x >> y[4:0] : x >> y[5:0];
      8: r = 64'd0 - x;
      9: begin
        if (y == 0) return {1'b0, d};
        r = x % y;
      end
      10: r = x ^ y;
      11: r = y;
      default: r = (cls == 4) ? $unsigned($signed({{32{x[31]}}, x[31:0]}) >>> y[4:0])
                              : $unsigned($signed(x) >>> y[5:0]);
    endcase
    if (cls == 4) r = r & m;
    return {1'b0, r};
  endfunction

  function automatic string tag(int op, int cls);
    if (!(cls == 7 || cls == 4) || op > 13) return "R9";
    if (op == 13) return "R7/R8";
    if (op == 3 || op == 9) return "R6";
    if (op == 6 || op == 7 || op == 12) return "R5";
    if (cls == 4) return "R4";
    return "R3";
  endfunction

  task automatic run(int op, int cls, bit sel, logic [63:0] d, s, i, string t);
    logic [64:0] e;
    e = model(op, cls, sel, d, s, i);
    @(negedge clk);
    in_valid = 1'b1; op_code = op[3:0]; op_class = cls[2:0]; src_sel = sel;
    dst_val = d; src_val = s; imm_val = i;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || err !== e[64] || wr_en !== !e[64] || (!e[64] && wr_data !== e[63:0])) begin
      fails++;
      $display("FAIL %s op=%0d cls=%0d sel=%0d: got v=%b we=%b err=%b data=%h, expected we=%b err=%b data=%h",
               t, op, cls, sel, out_valid, wr_en, err, wr_data, !e[64], e[64], e[63:0]);
    end
  endtask

  task automatic simple(string t, bit cond, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    simple("R10 reset quiet", {out_valid, wr_en, err} == 3'b000 && wr_data == 0, wr_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    simple("R1 idle no valid", out_valid == 1'b0, {63'd0, out_valid}, 64'd0);
    // R2: operand selection, same inputs differing only in src_sel
    run(0, 7, 1'b0, 64'd5, 64'd100, 64'd7, "R2");
    simple("R2 imm operand", wr_data == 64'd12, wr_data, 64'd12);
    run(0, 7, 1'b1, 64'd5, 64'd100, 64'd7, "R2");
    simple("R2 reg operand", wr_data == 64'd105, wr_data, 64'd105);
    // R7: directed byte swaps
    run(13, 4, 1'b1, 64'h1122_3344_5566_7788, 0, 64'd16, "R7");
    simple("R7 swap16", wr_data == 64'h8877, wr_data, 64'h8877);
    run(13, 4, 1'b0, 64'h1122_3344_5566_7788, 0, 64'd32, "R7");
    simple("R7 trunc32", wr_data == 64'h5566_7788, wr_data, 64'h5566_7788);
    run(13, 4, 1'b1, 64'h1122_3344_5566_7788, 0, 64'd64, "R7");
    simple("R7 swap64", wr_data == 64'h8877_6655_4433_2211, wr_data, 64'h8877_6655_4433_2211);
    run(13, 4, 1'b0, 64'h1122_3344_5566_7788, 0, 64'd8, "R8");
    // R6 directed: narrow modulo by zero keeps full destination
    run(9, 4, 1'b0, 64'hDEAD_BEEF_0000_0042, 0, 64'h1_0000_0000, "R6");
    simple("R6 mod0 keeps dst", wr_data == 64'hDEAD_BEEF_0000_0042, wr_data, 64'hDEAD_BEEF_0000_0042);
    // sweep
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 3; c++)
        for (int sel = 0; sel < 2; sel++)
          for (int a = 0; a < 11; a++)
            for (int b = 0; b < 11; b++) begin
              int cls;
              cls = (c == 0) ? 7 : (c == 1) ? 4 : 2;
              run(op, cls, sel[0], pat(a), pat(b), pat(b), tag(op, cls));
            end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    simple("R1 drop after idle", out_valid == 1'b0 && wr_en == 1'b0 && err == 1'b0, {61'd0, out_valid, wr_en, err}, 64'd0);
    finish_up();
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_up();
  end
endmodule